// File: doc/BRIEF.md
# Interrupt Request Aggregator

This block collects every interrupt source of a small 8-bit controller into one interrupt request for the CPU and one wake-from-sleep signal. It holds a sticky flag for each source: the 8-bit timer wrap, change detection on six port-A pins and four port-B pins, and eleven peripheral event lines. Each source has its own enable. The peripheral sources pass through a shared peripheral gate. A global gate sits above everything.

Pin-change detection runs each pin through a synchronizer and compares it against a reference copy. Every port read reloads that copy. A pin that changes in the same cycle as a read is therefore absorbed into the reference and raises no flag.

The wake path is taken before the global gate. While sleep is asserted, any source that runs from the system clock is masked out of the wake path, because such a source cannot run during sleep.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, all flags, enables and pin reference copies are 0, `irq` and `wake` are 0, and every register reads 0.
- R2: A `tmr_wrap` pulse sets the timer flag, which is control register (address 0) bit 2, at the next clock edge.
- R3: A level change on a port pin sets the change flag (control bit 0) only if that pin's enable bit is set. The flag is set on the third rising edge after the change: two for the synchronizer and one for the flag. Enable bits are address 1 bits 0..5 for A0..A5 and address 2 bits 4..7 for B4..B7.
- R4: `port_rd` reloads every pin reference from its synchronized value. A pin that differs from its reference keeps setting the change flag until a read. A cycle with `port_rd` high never sets the change flag, so a change that reaches the comparator in a read cycle is lost.
- R5: Flags are sticky. A register write stores the written bit value in a flag. A write of 0 in the same cycle as a new event leaves the flag at 1.
- R6: A pulse on `periph_evt[i]` sets peripheral flag i. Flags 0..7 are at address 3 bits 0..7 and flags 8..10 at address 4 bits 0..2. The matching enables use the same layout at addresses 5 and 6. Index order is: serial port, UART transmit, UART receive, timer 2, timer 1, comparator 1, comparator 2, ADC, EEPROM, oscillator fail, capture/compare.
- R7: `irq` = GE & ((TF & TE) | (CF & CE) | (PE & any(peripheral flag & enable))). The control bits are CE bit 3, TE bit 5, PE bit 6 and GE bit 7.
- R8: `wake` is the same combination as `irq` without the GE term, so an enabled source raises `wake` even while GE is 0.
- R9: While `sleep` is 1, the timer flag and the peripherals selected by `CLK_DEP_MASK` are excluded from `wake` but still reach `irq`.
- R10: `rd_data` shows the register at `rd_addr` in the same cycle. Control bits 1 and 4, port-B enable bits 0..3, address 4 and 6 bits 3..7, and address 7 all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_a | input | 6 | Raw port-A pins A0..A5 |
| pin_b | input | 4 | Raw port-B pins B4..B7 |
| port_rd | input | 1 | Port read strobe; reloads the pin references |
| tmr_wrap | input | 1 | 8-bit timer wrap pulse (FFh to 00h) |
| periph_evt | input | 11 | Peripheral event pulses |
| sleep | input | 1 | Device is in sleep |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Interrupt request to CPU |
| wake | output | 1 | Wake-from-sleep request |

## Verification
The bench builds the block with its defaults: a two-stage synchronizer, the timer treated as clock-dependent, and `CLK_DEP_MASK` selecting UART transmit, UART receive and timer 2. With these values the exact three-edge pin-to-flag latency can be checked. The read cycle can be placed on the very edge where a change reaches the comparator. A sleeping comparison can set a masked peripheral (timer 2) against an unmasked one (ADC).

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DW     = 8;
    localparam int AW     = 3;
    localparam int NPA    = 6;
    localparam int NPB    = 4;
    localparam int B_BASE = 4;
    localparam int NPER   = 11;
    localparam int NHI    = NPER - DW;

    localparam logic [AW-1:0] RA_CTL  = 3'd0;
    localparam logic [AW-1:0] RA_PINA = 3'd1;
    localparam logic [AW-1:0] RA_PINB = 3'd2;
    localparam logic [AW-1:0] RA_PFL0 = 3'd3;
    localparam logic [AW-1:0] RA_PFL1 = 3'd4;
    localparam logic [AW-1:0] RA_PEN0 = 3'd5;
    localparam logic [AW-1:0] RA_PEN1 = 3'd6;

    localparam int CB_CF = 0;
    localparam int CB_TF = 2;
    localparam int CB_CE = 3;
    localparam int CB_TE = 5;
    localparam int CB_PE = 6;
    localparam int CB_GE = 7;

    typedef struct packed {
        logic            cf;
        logic            tf;
        logic            ce;
        logic            te;
        logic            pe;
        logic            ge;
        logic [NPA-1:0]  pin_en_a;
        logic [NPB-1:0]  pin_en_b;
        logic [NPER-1:0] pfl;
        logic [NPER-1:0] pen;
    } regs_t;
endpackage

// File: rtl/irq_chg_det.sv
module irq_chg_det #(
    parameter int W        = 6,
    parameter int SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         rd,
    input  logic [W-1:0] en,
    output logic         hit
);
    localparam int LAST = SYNC_LEN - 1;

    typedef struct packed {
        logic [SYNC_LEN-1:0][W-1:0] sync;
        logic [W-1:0]               ref_v;
    } chg_t;

    chg_t st_d, st_q;
    logic [W-1:0] diff;

    always_comb begin
        st_d = st_q;
        st_d.sync[0] = pins;
        for (int s = 1; s < SYNC_LEN; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        if (rd) begin
            st_d.ref_v = st_q.sync[LAST];
        end
    end

    generate
        for (genvar p = 0; p < W; p++) begin : g_pin
            assign diff[p] = en[p] & (st_q.sync[LAST][p] ^ st_q.ref_v[p]);
        end
    endgenerate

    assign hit = ~rd & (|diff);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a read leaves the reference equal to the value seen by the comparator
    assert_ref_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (st_q.ref_v == $past(st_q.sync[LAST])));
endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import irq_pkg::*;
#(
    parameter logic [NPER-1:0] CLK_DEP_MASK = 11'h00E,
    parameter bit              TMR_CLK_DEP  = 1'b1
) (
    input  regs_t regs,
    input  logic  sleep,
    output logic  irq,
    output logic  wake
);
    logic [NPER-1:0] p_on, p_wake_mask;
    logic core_irq, core_wake, per_irq, per_wake;

    always_comb begin
        p_on        = regs.pfl & regs.pen;
        p_wake_mask = sleep ? ~CLK_DEP_MASK : '1;
        core_irq    = (regs.tf & regs.te) | (regs.cf & regs.ce);
        core_wake   = (regs.tf & regs.te & ~(sleep & TMR_CLK_DEP)) |
                      (regs.cf & regs.ce);
        per_irq     = regs.pe & (|p_on);
        per_wake    = regs.pe & (|(p_on & p_wake_mask));
        irq         = regs.ge & (core_irq | per_irq);
        wake        = core_wake | per_wake;
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_pkg::*;
#(
    parameter int              SYNC_LEN     = 2,
    parameter logic [NPER-1:0] CLK_DEP_MASK = 11'h00E,
    parameter bit              TMR_CLK_DEP  = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPA-1:0]  pin_a,
    input  logic [NPB-1:0]  pin_b,
    input  logic            port_rd,
    input  logic            tmr_wrap,
    input  logic [NPER-1:0] periph_evt,
    input  logic            sleep,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_data,
    output logic            irq,
    output logic            wake
);
    regs_t regs_d, regs_q;
    logic  hit_a, hit_b;

    irq_chg_det #(.W(NPA), .SYNC_LEN(SYNC_LEN)) u_chg_a (
        .clk(clk), .rst_n(rst_n), .pins(pin_a), .rd(port_rd),
        .en(regs_q.pin_en_a), .hit(hit_a));

    irq_chg_det #(.W(NPB), .SYNC_LEN(SYNC_LEN)) u_chg_b (
        .clk(clk), .rst_n(rst_n), .pins(pin_b), .rd(port_rd),
        .en(regs_q.pin_en_b), .hit(hit_b));

    irq_gate #(.CLK_DEP_MASK(CLK_DEP_MASK), .TMR_CLK_DEP(TMR_CLK_DEP)) u_gate (
        .regs(regs_q), .sleep(sleep), .irq(irq), .wake(wake));

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                RA_CTL: begin
                    regs_d.cf = wr_data[CB_CF];
                    regs_d.tf = wr_data[CB_TF];
                    regs_d.ce = wr_data[CB_CE];
                    regs_d.te = wr_data[CB_TE];
                    regs_d.pe = wr_data[CB_PE];
                    regs_d.ge = wr_data[CB_GE];
                end
                RA_PINA: regs_d.pin_en_a            = wr_data[NPA-1:0];
                RA_PINB: regs_d.pin_en_b            = wr_data[B_BASE +: NPB];
                RA_PFL0: regs_d.pfl[DW-1:0]         = wr_data;
                RA_PFL1: regs_d.pfl[NPER-1:DW]      = wr_data[NHI-1:0];
                RA_PEN0: regs_d.pen[DW-1:0]         = wr_data;
                RA_PEN1: regs_d.pen[NPER-1:DW]      = wr_data[NHI-1:0];
                default: ;
            endcase
        end
        regs_d.tf  = regs_d.tf | tmr_wrap;
        regs_d.cf  = regs_d.cf | hit_a | hit_b;
        regs_d.pfl = regs_d.pfl | periph_evt;
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            RA_CTL: begin
                rd_data[CB_CF] = regs_q.cf;
                rd_data[CB_TF] = regs_q.tf;
                rd_data[CB_CE] = regs_q.ce;
                rd_data[CB_TE] = regs_q.te;
                rd_data[CB_PE] = regs_q.pe;
                rd_data[CB_GE] = regs_q.ge;
            end
            RA_PINA: rd_data[NPA-1:0]      = regs_q.pin_en_a;
            RA_PINB: rd_data[B_BASE +: NPB] = regs_q.pin_en_b;
            RA_PFL0: rd_data               = regs_q.pfl[DW-1:0];
            RA_PFL1: rd_data[NHI-1:0]      = regs_q.pfl[NPER-1:DW];
            RA_PEN0: rd_data               = regs_q.pen[DW-1:0];
            RA_PEN1: rd_data[NHI-1:0]      = regs_q.pen[NPER-1:DW];
            default: rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assert_tmr_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_wrap |=> regs_q.tf);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.tf && !(wr_en && wr_addr == RA_CTL)) |=> regs_q.tf);

    assert_read_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd && !regs_q.cf && !(wr_en && wr_addr == RA_CTL)) |=> !regs_q.cf);

    assert_periph_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|periph_evt) |=> (|regs_q.pfl));

    assert_global_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.ge |-> !irq);

    assert_wake_covers_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !sleep) |-> wake);
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0] ctl;
        logic [7:0] pfl;
        logic [7:0] pen;
        logic       slp;
        logic       irq;
        logic       wake;
    } vec_t;

    localparam int NVEC = 13;
    localparam vec_t VEC [NVEC] = '{
        '{8'h24, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
        '{8'hA4, 8'h00, 8'h00, 1'b0, 1'b1, 1'b1},
        '{8'hA4, 8'h00, 8'h00, 1'b1, 1'b1, 1'b0},
        '{8'h84, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0},
        '{8'h09, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1},
        '{8'h89, 8'h00, 8'h00, 1'b1, 1'b1, 1'b1},
        '{8'h80, 8'h01, 8'h01, 1'b0, 1'b0, 1'b0},
        '{8'hC0, 8'h01, 8'h01, 1'b0, 1'b1, 1'b1},
        '{8'h40, 8'h01, 8'h01, 1'b0, 1'b0, 1'b1},
        '{8'hC0, 8'h08, 8'h08, 1'b1, 1'b1, 1'b0},
        '{8'hC0, 8'h08, 8'h08, 1'b0, 1'b1, 1'b1},
        '{8'hC0, 8'h10, 8'h08, 1'b0, 1'b0, 1'b0},
        '{8'hC0, 8'h80, 8'h80, 1'b1, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  pin_a = '0;
    logic [3:0]  pin_b = '0;
    logic        port_rd = 1'b0;
    logic        tmr_wrap = 1'b0;
    logic [10:0] periph_evt = '0;
    logic        sleep = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        irq, wake;

    int checks = 0;
    int errors = 0;

    irq_aggregator u0 (
        .clk(clk), .rst_n(rst_n), .pin_a(pin_a), .pin_b(pin_b),
        .port_rd(port_rd), .tmr_wrap(tmr_wrap), .periph_evt(periph_evt),
        .sleep(sleep), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .wake(wake));

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_port_rd();
        port_rd = 1'b1;
        tick();
        port_rd = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            check("R1 reg", v, 8'h00);
        end
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 wake", {7'd0, wake}, 8'h00);

        // R2: timer wrap sets bit 2
        tmr_wrap = 1'b1; tick(); tmr_wrap = 1'b0;
        rd(3'd0, v); check("R2 tf set", v & 8'h04, 8'h04);
        tick(2);
        rd(3'd0, v); check("R5 tf sticky", v & 8'h04, 8'h04);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R5 tf cleared", v, 8'h00);

        // R5: clear write racing a new event
        tmr_wrap = 1'b1; wr(3'd0, 8'h00); tmr_wrap = 1'b0;
        rd(3'd0, v); check("R5 race keeps flag", v & 8'h04, 8'h04);
        wr(3'd0, 8'h00);

        // R3: enable A1 only; change on A0 ignored
        wr(3'd1, 8'h02);
        pin_a = 6'b000001;
        tick(4);
        rd(3'd0, v); check("R3 disabled pin", v & 8'h01, 8'h00);
        do_port_rd();
        pin_a = 6'b000011;
        tick(2);
        rd(3'd0, v); check("R3 not before third edge", v & 8'h01, 8'h00);
        tick();
        rd(3'd0, v); check("R3 enabled pin on third edge", v & 8'h01, 8'h01);

        // R4: mismatch persists until a read
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R4 mismatch re-sets", v & 8'h01, 8'h01);
        do_port_rd();
        wr(3'd0, 8'h00);
        tick(2);
        rd(3'd0, v); check("R4 cleared after read", v & 8'h01, 8'h00);

        // R4: change landing in the read cycle is lost
        pin_a = 6'b000001;
        tick(2);
        do_port_rd();
        tick(3);
        rd(3'd0, v); check("R4 read-cycle miss", v & 8'h01, 8'h00);

        // R3: port B, enable B4 only
        wr(3'd2, 8'h10);
        pin_b = 4'b0010;
        tick(4);
        rd(3'd0, v); check("R3 B5 disabled", v & 8'h01, 8'h00);
        do_port_rd();
        pin_b = 4'b0011;
        tick(3);
        rd(3'd0, v); check("R3 B4 enabled", v & 8'h01, 8'h01);
        do_port_rd();
        wr(3'd0, 8'h00);

        // R6: peripheral flags
        periph_evt = 11'h400; tick(); periph_evt = '0;
        rd(3'd4, v); check("R6 capture flag hi", v, 8'h04);
        periph_evt = 11'h010; tick(); periph_evt = '0;
        rd(3'd3, v); check("R6 timer1 flag lo", v, 8'h10);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h00);
        rd(3'd3, v); check("R6 cleared lo", v, 8'h00);

        // R7 R8 R9: gating table
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd0, VEC[i].ctl);
            wr(3'd3, VEC[i].pfl);
            wr(3'd5, VEC[i].pen);
            sleep = VEC[i].slp;
            #1;
            check(VEC[i].slp ? "R9 irq" : "R7 irq", {7'd0, irq}, {7'd0, VEC[i].irq});
            check(VEC[i].slp ? "R9 wake" : "R8 wake", {7'd0, wake}, {7'd0, VEC[i].wake});
            sleep = 1'b0;
        end

        // R10: read masks of unused bits
        wr(3'd2, 8'hFF);
        rd(3'd2, v); check("R10 pinb", v, 8'hF0);
        wr(3'd0, 8'hFF);
        rd(3'd0, v); check("R10 ctl", v, 8'hED);
        wr(3'd6, 8'hFF);
        rd(3'd6, v); check("R10 pen hi", v, 8'h07);
        rd(3'd7, v); check("R10 unused addr", v, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule